// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a 32-bit interval timer that sits on a simple register bus. Software writes a start value, picks one of two tick rates and a run style, and turns the counter on. Each qualifying tick lowers the count by one. When a tick arrives while the count is already zero, the timer expires and raises a level interrupt. The interrupt stays high until software writes the clear register.

In periodic mode, an expiry refills the counter from the load register and counting goes on. In one-shot mode, the counter parks at zero and stays quiet until a new load value arrives. The two tick rates come in as one-cycle enable strobes from clock logic outside the block. Nominally these are a slow strobe near 2 kHz and a fast one near 508 kHz. Reads are combinational on the address. Writes take effect at the next rising clock edge.

Top module: `interval_timer`

## Requirements
- R1: After reset, the load value, the count, the control bits and the interrupt output are all 0.
- R2: The registers sit at these byte addresses: reload value at 0x0 (read/write), live count at 0x4 (read-only), control at 0x8 (read/write) and interrupt clear at 0xC (write-only). Control bit 0 is enable, bit 1 is mode (1 = periodic, 0 = one-shot) and bit 4 is tick select (0 = slow strobe, 1 = fast strobe). All other control bits read as 0. Reading 0xC returns 0.
- R3: A write to 0x0 puts the written value into the live count at the next edge. This holds even while the timer is counting, and it takes priority over a tick in the same cycle.
- R4: The count drops by one only in a cycle where enable is 1 and the strobe picked by the select bit is high. The other strobe has no effect.
- R5: While enable is 0, the count keeps its value whatever the strobes do.
- R6: A qualifying tick while the count is 0 is an expiry. It sets the interrupt output. In periodic mode it also refills the count from the reload value.
- R7: In one-shot mode, an expiry leaves the count at 0. Further ticks do not change the count or set the interrupt again until 0x0 is written.
- R8: A write of any data value to 0xC drops the interrupt output at the next edge.
- R9: When a clear write and an expiry fall in the same cycle, the interrupt output stays 1.
- R10: Writes to 0x4 leave the live count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_slow | input | 1 | Slow-rate tick enable strobe |
| tick_fast | input | 1 | Fast-rate tick enable strobe |
| irq | output | 1 | Level interrupt, high from expiry until cleared |

## Verification
The bench sweeps small reload values 0 to 4 over both modes and both tick sources. It drives the unselected strobe between ticks, so a decoder that listens to the wrong strobe shows up as a wrong count. An off-by-one design would either expire when the count reaches zero instead of on the tick after it, or refill to one less than the reload value. Either fault breaks the arithmetic cycle of length N+1 that the bench expects. A one-shot counter that wraps or fires again after its expiry is caught by the extra ticks sent after the flag is cleared. A clear that beats a same-cycle expiry leaves irq low where the bench expects it high. A load that loses to a same-cycle tick leaves the count one below the written value.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(12);
  localparam int EN_BIT = 0, MODE_BIT = 1, SEL_BIT = 4;

  logic [DATA_W-1:0] reload_q, count_q;
  logic ctl_en, ctl_mode, ctl_sel, parked, irq_q;

  wire wr_load  = bus_we && bus_addr == A_LOAD;
  wire wr_ctrl  = bus_we && bus_addr == A_CTRL;
  wire wr_clear = bus_we && bus_addr == A_CLEAR;
  wire tick_hit = ctl_en && (ctl_sel ? tick_fast : tick_slow);
  wire frozen   = parked && !ctl_mode;
  wire at_zero  = count_q == '0;
  wire expire   = tick_hit && at_zero && !frozen && !wr_load;

  wire [DATA_W-1:0] ctrl_word = {{(DATA_W-SEL_BIT-1){1'b0}}, ctl_sel, 2'b00, ctl_mode, ctl_en};

  assign bus_rdata = bus_addr == A_LOAD  ? reload_q :
                     bus_addr == A_COUNT ? count_q  :
                     bus_addr == A_CTRL  ? ctrl_word : '0;
  assign irq = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctl_en   <= 1'b0;
      ctl_mode <= 1'b0;
      ctl_sel  <= 1'b0;
    end else begin
      if (wr_load) reload_q <= bus_wdata;
      if (wr_ctrl) begin
        ctl_en   <= bus_wdata[EN_BIT];
        ctl_mode <= bus_wdata[MODE_BIT];
        ctl_sel  <= bus_wdata[SEL_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      parked  <= 1'b0;
    end else if (wr_load) begin
      count_q <= bus_wdata;
      parked  <= 1'b0;
    end else if (tick_hit && !frozen) begin
      if (at_zero) begin
        count_q <= ctl_mode ? reload_q : '0;
        parked  <= !ctl_mode;
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (expire)   irq_q <= 1'b1;
    else if (wr_clear) irq_q <= 1'b0;
  end

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> count_q == $past(bus_wdata)); // R3
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en && !wr_load |=> $stable(count_q)); // R5
  AST_EXPIRY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq); // R9
  AST_PERIODIC_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ctl_mode |=> count_q == $past(reload_q)); // R6
  AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !wr_load |=> count_q == '0 && !$rose(irq)); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear && !expire |=> !irq); // R8
  AST_RISE_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(expire)); // R6
  AST_NO_STRAY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_load && !tick_hit |=> $stable(count_q)); // R4
endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, bus_we = 0, tick_slow = 0, tick_fast = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  interval_timer uut (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
                      .tick_slow, .tick_fast, .irq);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse(logic s, logic f);
    @(negedge clk); tick_slow = s; tick_fast = f;
    @(negedge clk); tick_slow = 0; tick_fast = 0;
  endtask

  initial begin
    #(PERIOD*200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(4'h0, v); check("R1 load", v, 0);
    rd(4'h4, v); check("R1 count", v, 0);
    rd(4'h8, v); check("R1 ctrl", v, 0);
    check("R1 irq", irq, 0);

    wr(4'h0, 32'hDEADBEEF);
    rd(4'h0, v); check("R2 load readback", v, 32'hDEADBEEF);
    rd(4'h4, v); check("R3 count copy", v, 32'hDEADBEEF);
    wr(4'h8, 32'hFFFFFFFF);
    rd(4'h8, v); check("R2 ctrl bits", v, 32'h13);
    wr(4'h8, 0);
    rd(4'hC, v); check("R2 clear reads 0", v, 0);
    wr(4'h4, 5);
    rd(4'h4, v); check("R10 count write ignored", v, 32'hDEADBEEF);

    for (int mode = 0; mode < 2; mode++)
      for (int sel = 0; sel < 2; sel++)
        for (int n = 0; n < 5; n++) begin
          wr(4'h8, 0);
          wr(4'h0, n);
          wr(4'hC, 0);
          wr(4'h8, 32'(1 | (mode << 1) | (sel << 4)));
          for (int k = 1; k <= n + 3; k++) begin
            int ec;
            pulse(sel == 0, sel == 1);
            pulse(sel == 1, sel == 0);
            ec = mode ? n - (k % (n + 1)) : (k <= n ? n - k : 0);
            rd(4'h4, v); check(mode ? "R6 R4 periodic count" : "R4 oneshot count", v, ec);
            check("R6 irq", irq, k >= n + 1);
          end
          if (mode == 0) begin
            wr(4'hC, 32'h1234);
            check("R8 clear", irq, 0);
            pulse(sel == 0, sel == 1);
            pulse(sel == 0, sel == 1);
            rd(4'h4, v); check("R7 parked count", v, 0);
            check("R7 no refire", irq, 0);
          end
        end

    wr(4'h8, 0);
    wr(4'h0, 10);
    repeat (3) pulse(1, 1);
    rd(4'h4, v); check("R5 hold", v, 10);

    wr(4'h8, 32'h13);
    repeat (3) pulse(0, 1);
    rd(4'h4, v); check("R4 fast count", v, 7);
    @(negedge clk); bus_addr = 0; bus_we = 1; bus_wdata = 20; tick_fast = 1;
    @(negedge clk); bus_we = 0; tick_fast = 0;
    rd(4'h4, v); check("R3 load beats tick", v, 20);

    wr(4'h0, 0);
    wr(4'hC, 0);
    pulse(0, 1);
    check("R6 expiry", irq, 1);
    @(negedge clk); bus_addr = 4'hC; bus_we = 1; bus_wdata = 0; tick_fast = 1;
    @(negedge clk); bus_we = 0; tick_fast = 0;
    check("R9 expiry beats clear", irq, 1);
    wr(4'hC, 0);
    check("R8 clear any data", irq, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule